// File: doc/BRIEF.md
# Overlay Region Read Steering

This block decides whether array reads go to the main storage or to a small overlay region that shares the same address space. It holds two flags: an enable flag, which can be armed by several events, and a supply-status flag, which tracks a digital indicator that the programming supply sits inside its valid window. A read is steered to the overlay only while both flags are 1. Otherwise the read reaches the main-array word at the same address.

The enable flag can be armed in three ways: when the reset/power-down pin returns high, when power-on reset ends, or by a decoded toggle command. Each of these requires the supply to be in range during that cycle. Whenever the supply is out of range, the enable flag is forced to 0. While the overlay is steered in, the block-select bits of the read address are forced to zero. No main block can then be reached, and the caller's values for those bits have no effect.

Both flags are visible in a small status word. The select output and the masked address depend combinationally on the registered flags and the incoming address.

Top module: `ovl_gate`

## Requirements
- R1: `ovl_sel` is 1 exactly when the enable flag and the supply-status flag are both 1.
- R2: At each clock edge the supply-status flag takes the value `supply_ok` had at that edge.
- R3: The enable flag becomes 1 at an edge where `rstpd_n` is 1, `rstpd_n` was 0 at the previous edge, and `supply_ok` is 1.
- R4: The enable flag becomes 1 at an edge where `por_done` is 1 and `supply_ok` is 1.
- R5: At an edge where `tgl_cmd` is 1, `supply_ok` is 1, `rstpd_n` is 1 and neither set event of R3 or R4 is present, the enable flag inverts.
- R6: At any edge where `supply_ok` is 0, the enable flag becomes 0. This takes priority over every set and toggle event.
- R7: `tgl_cmd` has no effect while `supply_ok` is 0 or `rstpd_n` is 0.
- R8: While `ovl_sel` is 1, `arr_addr` equals `rd_addr` with bits [BLK_HI:BLK_LO] (default [17:13]) forced to 0.
- R9: While `ovl_sel` is 0, `arr_addr` equals `rd_addr`.
- R10: `stat_bits` bit 0 is the supply-status flag and bit 1 is the enable flag. All other bits are 0. After a synchronous reset both flags are 0.
- R11: When a set event (R3 or R4) and `tgl_cmd` arrive at the same edge with the supply in range, the enable flag becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Programming supply is inside its valid window |
| rstpd_n | input | 1 | Reset/power-down pin level, low means powered down |
| por_done | input | 1 | One-cycle pulse at the end of power-on reset |
| tgl_cmd | input | 1 | One-cycle pulse from the command decoder: toggle overlay enable |
| rd_addr | input | ADDR_W (18) | Read address from the access logic |
| ovl_sel | output | 1 | Steer the read to the overlay region |
| arr_addr | output | ADDR_W (18) | Address to the array, with block bits masked when the overlay is selected |
| stat_bits | output | STAT_W (8) | Status word: bit 0 supply status, bit 1 enable |

## Verification
The assertions assume that `supply_ok`, `rstpd_n`, `por_done` and `tgl_cmd` are already synchronous to `clk`, so each one holds a single level at every edge. They also assume that the pin history is only meaningful after the first edge out of reset, which is why the checks that use `$past` wait one cycle past reset. The stimulus changes every input only on the falling clock edge. It drives the pin low for at least one full cycle before it releases it, so every return to high is seen as a clean edge. It also places combined events, such as a set event together with a toggle or a supply drop together with a set event, on single edges.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int ADDR_W_DEF = 18;
    localparam int BLK_LO_DEF = 13;
    localparam int BLK_HI_DEF = 17;
    localparam int STAT_W_DEF = 8;

    // status word layout (R10)
    localparam int STAT_ST_BIT = 0;
    localparam int STAT_EN_BIT = 1;

    typedef struct packed {
        logic in_range;
        logic pin_rise;
        logic por_exit;
        logic cmd_tgl;
        logic pin_up;
    } ovl_trig_t;

    typedef struct packed {
        logic en;
        logic st;
    } ovl_flags_t;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_SET   = 2'd2,
        ACT_FLIP  = 2'd3
    } ovl_act_t;

    // Priority: supply out of range, then set events, then command toggle.
    function automatic ovl_act_t ovl_decide(input ovl_trig_t t);
        ovl_act_t a;
        if (!t.in_range)
            a = ACT_CLEAR;
        else if (t.pin_rise || t.por_exit)
            a = ACT_SET;
        else if (t.cmd_tgl && t.pin_up)
            a = ACT_FLIP;
        else
            a = ACT_HOLD;
        return a;
    endfunction

    function automatic logic ovl_apply(input ovl_act_t a, input logic cur);
        logic n;
        case (a)
            ACT_CLEAR: n = 1'b0;
            ACT_SET:   n = 1'b1;
            ACT_FLIP:  n = ~cur;
            default:   n = cur;
        endcase
        return n;
    endfunction

    function automatic logic in_blk_field(input int idx, input int lo, input int hi);
        return (idx >= lo) && (idx <= hi);
    endfunction

endpackage

// File: rtl/ovl_supply_track.sv
module ovl_supply_track (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    output logic st_q
);
    always_ff @(posedge clk) begin
        if (rst)
            st_q <= 1'b0;
        else
            st_q <= supply_ok;
    end
endmodule

// File: rtl/ovl_pin_edge.sv
module ovl_pin_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b1;
        else
            prev_q <= pin_n;
    end

    assign rise = pin_n & ~prev_q;
endmodule

// File: rtl/ovl_enable_ctl.sv
module ovl_enable_ctl
    import ovl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ovl_trig_t trig,
    output logic      en_q
);
    ovl_act_t act;

    always_comb act = ovl_decide(trig);

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else
            en_q <= ovl_apply(act, en_q);
    end
endmodule

// File: rtl/ovl_addr_mask.sv
module ovl_addr_mask
    import ovl_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int BLK_LO = BLK_LO_DEF,
    parameter int BLK_HI = BLK_HI_DEF
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (in_blk_field(i, BLK_LO, BLK_HI)) begin : g_blk
            assign addr_out[i] = addr_in[i] & ~sel;
        end else begin : g_pass
            assign addr_out[i] = addr_in[i];
        end
    end
endmodule

// File: rtl/ovl_gate.sv
module ovl_gate
    import ovl_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int BLK_LO = BLK_LO_DEF,
    parameter int BLK_HI = BLK_HI_DEF,
    parameter int STAT_W = STAT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic              rstpd_n,
    input  logic              por_done,
    input  logic              tgl_cmd,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              ovl_sel,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [STAT_W-1:0] stat_bits
);
    ovl_flags_t flags;
    ovl_trig_t  trig;
    logic       pin_rise;

    ovl_supply_track u_st (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .st_q      (flags.st)
    );

    ovl_pin_edge u_pin (
        .clk   (clk),
        .rst   (rst),
        .pin_n (rstpd_n),
        .rise  (pin_rise)
    );

    always_comb begin
        trig.in_range = supply_ok;
        trig.pin_rise = pin_rise;
        trig.por_exit = por_done;
        trig.cmd_tgl  = tgl_cmd;
        trig.pin_up   = rstpd_n;
    end

    ovl_enable_ctl u_en (
        .clk  (clk),
        .rst  (rst),
        .trig (trig),
        .en_q (flags.en)
    );

    assign ovl_sel = flags.en & flags.st;

    ovl_addr_mask #(
        .ADDR_W (ADDR_W),
        .BLK_LO (BLK_LO),
        .BLK_HI (BLK_HI)
    ) u_mask (
        .sel      (ovl_sel),
        .addr_in  (rd_addr),
        .addr_out (arr_addr)
    );

    always_comb begin
        stat_bits              = '0;
        stat_bits[STAT_ST_BIT] = flags.st;
        stat_bits[STAT_EN_BIT] = flags.en;
    end
endmodule

// File: rtl/ovl_gate_chk.sv
module ovl_gate_chk
    import ovl_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int BLK_LO = BLK_LO_DEF,
    parameter int BLK_HI = BLK_HI_DEF,
    parameter int STAT_W = STAT_W_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              supply_ok,
    input logic              rstpd_n,
    input logic              por_done,
    input logic              tgl_cmd,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              ovl_sel,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [STAT_W-1:0] stat_bits
);
    logic pv;
    always_ff @(posedge clk) begin
        if (rst) pv <= 1'b0;
        else     pv <= 1'b1;
    end

    // R1
    a_r1_sel_needs_both: assert property (@(posedge clk) disable iff (rst)
        ovl_sel == (stat_bits[STAT_EN_BIT] && stat_bits[STAT_ST_BIT]));

    // R2
    a_r2_status_tracks: assert property (@(posedge clk) disable iff (rst || !pv)
        stat_bits[STAT_ST_BIT] == $past(supply_ok));

    // R3
    a_r3_pin_sets: assert property (@(posedge clk) disable iff (rst || !pv)
        (rstpd_n && !$past(rstpd_n) && supply_ok) |=> stat_bits[STAT_EN_BIT]);

    // R4
    a_r4_por_sets: assert property (@(posedge clk) disable iff (rst)
        (por_done && supply_ok) |=> stat_bits[STAT_EN_BIT]);

    // R5
    a_r5_cmd_flips: assert property (@(posedge clk) disable iff (rst || !pv)
        (tgl_cmd && supply_ok && rstpd_n && $past(rstpd_n) && !por_done)
        |=> stat_bits[STAT_EN_BIT] != $past(stat_bits[STAT_EN_BIT]));

    // R6
    a_r6_supply_clears: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !stat_bits[STAT_EN_BIT]);

    // R7
    a_r7_cmd_ignored_pd: assert property (@(posedge clk) disable iff (rst)
        (!rstpd_n && supply_ok && !por_done)
        |=> stat_bits[STAT_EN_BIT] == $past(stat_bits[STAT_EN_BIT]));

    // R8
    a_r8_block_masked: assert property (@(posedge clk) disable iff (rst)
        ovl_sel |-> (arr_addr[BLK_HI:BLK_LO] == '0));

    // R9
    a_r9_pass_through: assert property (@(posedge clk) disable iff (rst)
        !ovl_sel |-> (arr_addr == rd_addr));

    // R10
    a_r10_spare_zero: assert property (@(posedge clk) disable iff (rst)
        $countones(stat_bits) <= 2 && (stat_bits[STAT_W-1:2] == '0));
endmodule

bind ovl_gate ovl_gate_chk #(
    .ADDR_W (ADDR_W),
    .BLK_LO (BLK_LO),
    .BLK_HI (BLK_HI),
    .STAT_W (STAT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .rstpd_n   (rstpd_n),
    .por_done  (por_done),
    .tgl_cmd   (tgl_cmd),
    .rd_addr   (rd_addr),
    .ovl_sel   (ovl_sel),
    .arr_addr  (arr_addr),
    .stat_bits (stat_bits)
);

// File: tb/test_ovl_gate.sv
`timescale 1ns/1ps
module test_ovl_gate;
    localparam int AW = 18;
    localparam int SW = 8;
    localparam logic [AW-1:0] BLK_MASK = 18'h3E000;

    typedef struct {
        logic          sel;
        logic [AW-1:0] addr;
        logic [SW-1:0] stat;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          supply_ok = 1'b1;
    logic          rstpd_n = 1'b1;
    logic          por_done = 1'b0;
    logic          tgl_cmd = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          ovl_sel;
    logic [AW-1:0] arr_addr;
    logic [SW-1:0] stat_bits;

    int n_chk = 0;
    int n_bad = 0;
    exp_t q[$];
    event sample_ev;

    // bench model state
    logic m_en = 1'b0, m_st = 1'b0, m_pd = 1'b1;

    always #2 clk = ~clk;

    ovl_gate i_ovl_gate (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .rstpd_n   (rstpd_n),
        .por_done  (por_done),
        .tgl_cmd   (tgl_cmd),
        .rd_addr   (rd_addr),
        .ovl_sel   (ovl_sel),
        .arr_addr  (arr_addr),
        .stat_bits (stat_bits)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic sup, input logic pin, input logic por, input logic tgl,
                        input logic [AW-1:0] addr, input string tag);
        exp_t e;
        logic rise;
        @(negedge clk);
        supply_ok = sup; rstpd_n = pin; por_done = por; tgl_cmd = tgl; rd_addr = addr;
        rise = pin && !m_pd;
        if (!sup)                    m_en = 1'b0;
        else if (rise || por)        m_en = 1'b1;
        else if (tgl && pin)         m_en = ~m_en;
        m_st = sup;
        m_pd = pin;
        e.sel  = m_en && m_st;
        e.addr = e.sel ? (addr & ~BLK_MASK) : addr;
        e.stat = {6'b0, m_en, m_st};
        e.tag  = tag;
        q.push_back(e);
        @(posedge clk);
        #1;
        ->sample_ev;
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(sample_ev);
            if (q.size() == 0) begin
                check("scoreboard", "queue", 32'd0, 32'd1);
            end else begin
                e = q.pop_front();
                check(e.tag, "ovl_sel", {31'b0, ovl_sel}, {31'b0, e.sel});
                check(e.tag, "arr_addr", {14'b0, arr_addr}, {14'b0, e.addr});
                check(e.tag, "stat_bits", {24'b0, stat_bits}, {24'b0, e.stat});
            end
        end
    end

    initial begin : watchdog
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : driver
        rd_addr = 18'h3FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state: both flags 0, pass-through address
        check("R10", "reset stat", {24'b0, stat_bits}, 32'd0);
        check("R10", "reset sel", {31'b0, ovl_sel}, 32'd0);
        check("R9", "reset addr", {14'b0, arr_addr}, {14'b0, 18'h3FFFF});
        rst = 1'b0;

        step(1, 1, 0, 0, 18'h3FFFF, "R2_R9_idle");
        step(1, 1, 1, 0, 18'h3FFFF, "R4_R8_por_set");
        step(1, 1, 0, 0, 18'h21234, "R8_R1_selected");
        step(1, 1, 0, 1, 18'h3FFFF, "R5_toggle_off");
        step(1, 1, 0, 1, 18'h1FFFF, "R5_toggle_on");
        step(0, 1, 0, 0, 18'h2A5A5, "R6_supply_drop");
        step(0, 1, 1, 0, 18'h2A5A5, "R6_por_blocked");
        step(0, 1, 0, 1, 18'h3C001, "R7_cmd_no_supply");
        step(1, 1, 0, 0, 18'h3C001, "R1_status_only");
        step(1, 0, 0, 0, 18'h3C001, "R3_pin_low");
        step(1, 0, 0, 1, 18'h3C001, "R7_cmd_pin_low");
        step(1, 1, 0, 0, 18'h3C001, "R3_pin_rise_set");
        step(1, 0, 0, 0, 18'h0FFFF, "R3_pin_low_hold");
        step(0, 0, 0, 0, 18'h0FFFF, "R6_clear_pd");
        step(0, 1, 0, 0, 18'h0FFFF, "R3_rise_no_supply");
        step(1, 1, 0, 0, 18'h3E000, "R3_not_armed");
        step(1, 1, 1, 1, 18'h3E000, "R11_por_and_cmd");
        step(1, 0, 0, 0, 18'h3E000, "R11_pin_low");
        step(1, 1, 0, 1, 18'h35555, "R11_rise_and_cmd");
        step(1, 1, 0, 0, 18'h12345, "R8_low_bits_kept");
        step(0, 1, 1, 1, 18'h12345, "R6_priority");
        step(1, 1, 0, 0, 18'h12345, "R2_back_in_range");

        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule